// File: doc/BRIEF.md
# Dual-Channel DAC Register Front End with Two-Wire Write Port

This block is the digital register side of a two-channel 16-bit DAC. A two-wire (I2C) slave that accepts writes only receives a 24-bit word after its address byte. The word has three bytes, in this order:

- a command/channel byte: command in bits 7..4, channel select in bits 3..0;
- the high data byte;
- the low data byte.

Each channel has an input register and a DAC register. A completed word writes the input register, the DAC register, or both, depending on the command. A word may also power a channel down.

An active-low load pin, `load_ni`, acts alongside the bus. A falling edge powers every channel up at once. When no word is in progress, the same edge also copies the input registers into the DAC registers. If the pin is still low when a word completes, the word's DAC update goes through even for a write-only command, and any power-down in that word is cancelled.

All bus and load inputs pass through two-flop synchronisers running on the system clock. All state changes are made by that clock.

Top module: `dacfe_top`

## Requirements
- R1: After reset, both DAC outputs read 0, both power-down flags are 0 and the slave does not drive SDA.
- R2: The slave drives an acknowledge (`sda_oe_o`=1 during the 9th clock) only for the address byte `{SLAVE_ADDR, 0}` and for the data bytes that follow it. Any other address byte gets no acknowledge, and the bus is ignored until the next START, so the bytes that follow change no register.
- R3: Command 4'h0 writes the input register of the selected channel and leaves its DAC output unchanged while the load pin is high.
- R4: Command 4'h3 writes the data into both the input register and the DAC register of the selected channel.
- R5: Command 4'h1 copies the selected channel's input register into its DAC register.
- R6: Channel select 4'h0 means channel A, 4'h1 means channel B and 4'hF means both channels. Any other select value, or any command other than 4'h0, 4'h1, 4'h3 and 4'h4, leaves every output unchanged.
- R7: Command 4'h4 with the load pin high sets the power-down flag of each selected channel. `pd_o` bit 0 is channel A and bit 1 is channel B.
- R8: A falling edge on the load pin while no data byte of a word has started copies every input register into its DAC register.
- R9: A falling edge on the load pin clears every power-down flag, including when a word is only part way through.
- R10: A load pulse during a word that is only part way through changes no DAC output.
- R11: If the load pin is low when a word completes, the DAC register of each selected channel is updated, even for command 4'h0. A power-down command in that word sets no flag.
- R12: A START or STOP before the third data byte has been acknowledged discards the partial word, and no register changes.
- R13: With the load pin held high, DAC outputs change only as a result of completed update commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| load_ni | input | 1 | Active-low asynchronous load / power-up pin |
| dac_a_o | output | 16 | Channel A DAC register |
| dac_b_o | output | 16 | Channel B DAC register |
| pd_o | output | 2 | Power-down flags, bit 0 = A, bit 1 = B |

## Verification
The hardest cases to reach are the ones where a load pulse and a word overlap. There are two of them:

- A pulse that lands between the first and second data bytes. It must power the channels up and must not copy the stale input register into the DAC register.
- A load level that is still low when the 9th clock of the third data byte falls.

The bench builds both from its bus-master tasks. To create the first case, it stops after the command byte's acknowledge, pulses the pin while SCL rests low, and then finishes the word. To create the second case, it drives the pin low before the START and keeps it low through a write-only word and then a power-down word. For each case the bench then compares the DAC outputs and power flags against values it expects.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [3:0] {
    CMD_WRITE  = 4'h0,
    CMD_UPDATE = 4'h1,
    CMD_WR_UPD = 4'h3,
    CMD_PWRDN  = 4'h4
  } cmd_e;

  localparam logic [3:0] SEL_ALL = 4'hF;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [3:0]        sel;
    logic [DATA_W-1:0] data;
  } word_t;

  typedef enum logic [1:0] {RX_IDLE, RX_ADDR, RX_DATA, RX_SKIP} rx_state_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/dacfe_i2c_rx.sv
module dacfe_i2c_rx
  import dacfe_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h72
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_i,
  input  logic  sda_i,
  output logic  sda_oe_o,
  output logic  word_done_o,
  output word_t word_o,
  output logic  busy_o
);
  localparam int NBYTES = 3;

  rx_state_e   state_q;
  logic        scl_q, sda_q, ack_ph_q;
  logic [3:0]  bit_cnt_q;
  logic [1:0]  byte_idx_q;
  logic [7:0]  shreg_q;
  logic [7:0]  bytes_q [NBYTES];

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_ev = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_ev  = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      ack_ph_q    <= 1'b0;
      bit_cnt_q   <= '0;
      byte_idx_q  <= '0;
      shreg_q     <= '0;
      sda_oe_o    <= 1'b0;
      word_done_o <= 1'b0;
      for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
    end else begin
      scl_q       <= scl_i;
      sda_q       <= sda_i;
      word_done_o <= 1'b0;
      if (start_ev) begin
        state_q    <= RX_ADDR;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        ack_ph_q   <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (stop_ev) begin
        state_q  <= RX_IDLE;
        ack_ph_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (state_q == RX_ADDR || state_q == RX_DATA) begin
        if (scl_rise && !ack_ph_q && bit_cnt_q != 4'd8) begin
          shreg_q   <= {shreg_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall) begin
          if (ack_ph_q) begin
            // end of 9th clock: release SDA, commit byte position
            ack_ph_q  <= 1'b0;
            sda_oe_o  <= 1'b0;
            bit_cnt_q <= '0;
            if (state_q == RX_ADDR) begin
              state_q <= RX_DATA;
            end else if (byte_idx_q == 2'(NBYTES - 1)) begin
              byte_idx_q  <= '0;
              word_done_o <= 1'b1;
            end else begin
              byte_idx_q <= byte_idx_q + 2'd1;
            end
          end else if (bit_cnt_q == 4'd8) begin
            if (state_q == RX_ADDR) begin
              if (shreg_q == {SLAVE_ADDR, 1'b0}) begin
                sda_oe_o <= 1'b1;
                ack_ph_q <= 1'b1;
              end else begin
                state_q <= RX_SKIP;
              end
            end else begin
              sda_oe_o            <= 1'b1;
              ack_ph_q            <= 1'b1;
              bytes_q[byte_idx_q] <= shreg_q;
            end
          end
        end
      end
    end
  end

  assign word_o = {bytes_q[0], bytes_q[1], bytes_q[2]};
  assign busy_o = (state_q == RX_DATA) &&
                  (byte_idx_q != '0 || bit_cnt_q != '0 || ack_ph_q);
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          word_done_i,
  input  word_t                         word_i,
  input  logic                          load_low_i,
  input  logic                          load_fall_i,
  input  logic                          busy_i,
  output logic [NUM_CH-1:0][DATA_W-1:0] dac_o,
  output logic [NUM_CH-1:0]             pd_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] in_q;
    wire sel = (word_i.sel == 4'(ch)) || (word_i.sel == SEL_ALL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q      <= '0;
        dac_o[ch] <= '0;
        pd_o[ch]  <= 1'b0;
      end else begin
        if (load_fall_i) pd_o[ch] <= 1'b0;
        if (load_fall_i && !busy_i) dac_o[ch] <= in_q;
        if (word_done_i && sel) begin
          unique case (word_i.cmd)
            CMD_WRITE: begin
              in_q <= word_i.data;
              if (load_low_i) dac_o[ch] <= word_i.data;
            end
            CMD_UPDATE: dac_o[ch] <= in_q;
            CMD_WR_UPD: begin
              in_q      <= word_i.data;
              dac_o[ch] <= word_i.data;
            end
            CMD_PWRDN: if (!load_low_i) pd_o[ch] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h72
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        load_ni,
  output logic [15:0] dac_a_o,
  output logic [15:0] dac_b_o,
  output logic [1:0]  pd_o
);
  localparam int NUM_CH = 2;

  logic scl_s, sda_s, load_s, load_q;
  logic word_done, busy;
  word_t word;
  logic [NUM_CH-1:0][DATA_W-1:0] dac;

  dacfe_sync #(.W(3), .RST_VAL(1'b1)) i_sync (
    .clk_i, .rst_ni,
    .d_i({scl_i, sda_i, load_ni}),
    .q_o({scl_s, sda_s, load_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= load_s;
  end

  wire load_low  = ~load_s;
  wire load_fall = load_q & ~load_s;

  dacfe_i2c_rx #(.SLAVE_ADDR(SLAVE_ADDR)) i_rx (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s),
    .sda_oe_o, .word_done_o(word_done), .word_o(word), .busy_o(busy)
  );

  dacfe_regs #(.NUM_CH(NUM_CH)) i_regs (
    .clk_i, .rst_ni,
    .word_done_i(word_done), .word_i(word),
    .load_low_i(load_low), .load_fall_i(load_fall), .busy_i(busy),
    .dac_o(dac), .pd_o
  );

  assign dac_a_o = dac[0];
  assign dac_b_o = dac[1];
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        sda_oe_o,
  input logic        load_fall,
  input logic        load_low,
  input logic        busy,
  input logic        word_done,
  input logic [15:0] dac_a_o,
  input logic [15:0] dac_b_o,
  input logic [1:0]  pd_o
);
  // R2
  ack_on_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  // R9
  load_powers_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fall |=> pd_o == 2'b00);

  // R10
  midword_load_no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_fall && busy && !word_done) |=> ($stable(dac_a_o) && $stable(dac_b_o)));

  // R11
  pd_suppressed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done && load_low) |=> ((pd_o & ~$past(pd_o)) == 2'b00));

  // R13
  dac_change_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dac_a_o) || !$stable(dac_b_o)) |-> $past(word_done || load_fall));
endmodule

bind dacfe_top dacfe_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .load_fall(load_fall), .load_low(load_low), .busy(busy), .word_done(word_done),
  .dac_a_o(dac_a_o), .dac_b_o(dac_b_o), .pd_o(pd_o)
);

// File: tb/test_dacfe_top.sv
module test_dacfe_top;
  localparam logic [6:0] ADDR = 7'h72;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, load_n = 1'b1;
  logic sda_oe;
  logic [15:0] dac_a, dac_b;
  logic [1:0] pd;
  wire sda_line = sda_drv & ~sda_oe;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dacfe_top #(.SLAVE_ADDR(ADDR)) i_dacfe_top (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .load_ni(load_n),
    .dac_a_o(dac_a), .dac_b_o(dac_b), .pd_o(pd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; tick(H);
    scl = 1'b1;     tick(H);
    sda_drv = 1'b0; tick(H);
    scl = 1'b0;     tick(H);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; tick(H);
    scl = 1'b1;     tick(H);
    sda_drv = 1'b1; tick(H);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(H);
      scl = 1'b1;     tick(H);
      scl = 1'b0;
    end
    sda_drv = 1'b1; tick(H);
    scl = 1'b1;     tick(H / 2);
    ack = ~sda_line; tick(H / 2);
    scl = 1'b0;     tick(H);
  endtask

  task automatic send_word(input logic [7:0] a8, input logic [3:0] cmd,
                           input logic [3:0] sel, input logic [15:0] d,
                           output logic [3:0] acks);
    i2c_start();
    i2c_byte(a8, acks[3]);
    i2c_byte({cmd, sel}, acks[2]);
    i2c_byte(d[15:8], acks[1]);
    i2c_byte(d[7:0], acks[0]);
    i2c_stop();
    tick(H);
  endtask

  task automatic wr(input logic [3:0] cmd, input logic [3:0] sel, input logic [15:0] d);
    logic [3:0] acks;
    send_word({ADDR, 1'b0}, cmd, sel, d, acks);
  endtask

  task automatic load_pulse();
    load_n = 1'b0; tick(H);
    load_n = 1'b1; tick(H);
  endtask

  task automatic t_reset();
    chk("R1 dac_a", dac_a, 0);
    chk("R1 dac_b", dac_b, 0);
    chk("R1 pd", pd, 0);
    chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_address();
    logic [3:0] acks;
    send_word({ADDR, 1'b0}, 4'h3, 4'h0, 16'h0101, acks);
    chk("R2 ack on match", acks, 4'hF);
    send_word({ADDR ^ 7'h01, 1'b0}, 4'h3, 4'h0, 16'h7777, acks);
    chk("R2 no ack on mismatch", acks, 4'h0);
    chk("R2 mismatch ignored", dac_a, 16'h0101);
    send_word({ADDR, 1'b1}, 4'h3, 4'h0, 16'h7777, acks);
    chk("R2 no ack on read bit", acks, 4'h0);
    chk("R2 read ignored", dac_a, 16'h0101);
  endtask

  task automatic t_write_update();
    wr(4'h3, 4'h0, 16'h1234);
    wr(4'h3, 4'h1, 16'hABCD);
    chk("R4 dac_a", dac_a, 16'h1234);
    chk("R4 dac_b", dac_b, 16'hABCD);
  endtask

  task automatic t_write_only();
    wr(4'h0, 4'h0, 16'h5555);
    chk("R3/R13 dac_a held", dac_a, 16'h1234);
    wr(4'h1, 4'h0, 16'h0000);
    chk("R5 dac_a updated", dac_a, 16'h5555);
    chk("R5 dac_b untouched", dac_b, 16'hABCD);
  endtask

  task automatic t_select();
    wr(4'h3, 4'hF, 16'h0F0F);
    chk("R6 all a", dac_a, 16'h0F0F);
    chk("R6 all b", dac_b, 16'h0F0F);
    wr(4'h3, 4'h2, 16'h9999);
    chk("R6 bad sel a", dac_a, 16'h0F0F);
    chk("R6 bad sel b", dac_b, 16'h0F0F);
    wr(4'h7, 4'hF, 16'h9999);
    chk("R6 bad cmd a", dac_a, 16'h0F0F);
    chk("R6 bad cmd pd", pd, 0);
  endtask

  task automatic t_powerdown();
    wr(4'h4, 4'h0, 16'h0000);
    chk("R7 pd A", pd, 2'b01);
    wr(4'h4, 4'hF, 16'h0000);
    chk("R7 pd all", pd, 2'b11);
  endtask

  task automatic t_load_update();
    wr(4'h0, 4'h0, 16'h1111);
    wr(4'h0, 4'h1, 16'h2222);
    chk("R13 held a", dac_a, 16'h0F0F);
    load_pulse();
    chk("R8 a", dac_a, 16'h1111);
    chk("R8 b", dac_b, 16'h2222);
    chk("R9 pd clear", pd, 2'b00);
  endtask

  task automatic t_load_midword();
    logic ack;
    wr(4'h4, 4'hF, 16'h0000);
    wr(4'h0, 4'h0, 16'h3333);
    i2c_start();
    i2c_byte({ADDR, 1'b0}, ack);
    i2c_byte({4'h3, 4'h0}, ack);
    load_pulse();
    chk("R9 midword pd clear", pd, 2'b00);
    chk("R10 midword dac_a held", dac_a, 16'h1111);
    i2c_byte(8'h44, ack);
    i2c_byte(8'h44, ack);
    i2c_stop();
    tick(H);
    chk("R10 word completes", dac_a, 16'h4444);
  endtask

  task automatic t_load_low_complete();
    load_n = 1'b0; tick(H);
    wr(4'h0, 4'h1, 16'h5A5A);
    chk("R11 write-only updates b", dac_b, 16'h5A5A);
    wr(4'h4, 4'hF, 16'h0000);
    chk("R11 pd suppressed", pd, 2'b00);
    load_n = 1'b1; tick(H);
  endtask

  task automatic t_abort();
    logic ack;
    i2c_start();
    i2c_byte({ADDR, 1'b0}, ack);
    i2c_byte({4'h3, 4'h0}, ack);
    i2c_byte(8'h12, ack);
    i2c_stop();
    tick(H);
    chk("R12 stop abort", dac_a, 16'h4444);
    i2c_start();
    i2c_byte({ADDR, 1'b0}, ack);
    i2c_byte({4'h3, 4'h0}, ack);
    i2c_byte(8'h34, ack);
    i2c_start();
    i2c_byte({ADDR, 1'b0}, ack);
    i2c_byte({4'h3, 4'h1}, ack);
    i2c_byte(8'h60, ack);
    i2c_byte(8'h06, ack);
    i2c_stop();
    tick(H);
    chk("R12 restart abort a", dac_a, 16'h4444);
    chk("R12 restart word b", dac_b, 16'h6006);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_address();
    t_write_update();
    t_write_only();
    t_select();
    t_powerdown();
    t_load_update();
    t_load_midword();
    t_load_low_complete();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule